// File: doc/BRIEF.md
# Conditional Sum Adder

This block adds two 32-bit operands and an incoming carry using the conditional-sum method. The operands are cut into 4-bit digits. Every digit works out, side by side, the sum and carry it would give with a zero carry-in and with a one carry-in. A doubling tree then joins neighbouring groups in pairs: 2 digits, then 4, then 8, and so on, until one pair of candidates spans the whole word. The real carry-in picks between the two final candidates.

The adder is combinational from the operands to the final select. A parameter can place a register after the select, so the result appears at the rising edge after the operands. That register is present by default. Parameters set the word width and the digit width, which must divide into a power-of-two number of digits. A further parameter chooses how each bit's propagate term is formed, either as OR or as XOR of the two operand bits.

Top module: `cond_sum_adder`

## Requirements
- R1: `{cout, sum}` equals the 33-bit value `a + b + cin`. `cout` is bit 32 of that value and `sum` is bits 31..0.
- R2: Each 4-bit digit forms its carry-in-0 and carry-in-1 candidates by lookahead over its own bits. A carry made in one digit reaches the next digit, so `0x0000000F + 0x00000001` gives `0x00000010`.
- R3: For every digit and every merged group, the carry-in-1 candidate `{carry, sum}` is exactly one more than the carry-in-0 candidate. The carry-in-1 carry is therefore never 0 while the carry-in-0 carry is 1.
- R4: In a pair merge the low group's sums pass through unchanged. The low group's carries choose the high group's candidates: with both at 0, both take the high carry-in-0 candidate; with both at 1, both take the high carry-in-1 candidate; when they differ, each keeps its own. A carry therefore crosses group borders of 2, 4 and 8 digits correctly.
- R5: The final result is the carry-in-1 candidate when `cin` is 1 and the carry-in-0 candidate when `cin` is 0. For the same operands, the two results differ by exactly one.
- R6: While `rst_n` is low at a rising clock edge, `sum` and `cout` become 0 at that edge, whatever the operands are.
- R7: A carry that runs the full width is handled. `0xFFFFFFFF + 0x00000000` with `cin = 1`, and `0xFFFFFFFF + 0x00000001` with `cin = 0`, both give `sum = 0` and `cout = 1`.
- R8: With the output register present (the default), `sum` and `cout` take the result of the operands present at a rising edge and hold it until the next rising edge. An operand change between edges is not visible at the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Synchronous reset, active low |
| a | input | 32 | First operand |
| b | input | 32 | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | 32 | Sum bits |
| cout | output | 1 | Carry out of bit 31 |

## Verification
Two functions can act in the same cycle: the final selection by `cin`, and a merge-tree carry that crosses digit and group borders. The bench applies the same operands back to back with `cin` at 0 and then at 1. It uses operands such as all-ones, runs of ones ending at a group border, and alternating bit patterns, so that the selected candidate was itself produced by high groups that switched on a low-group carry. A behavioural reference sum, queued one cycle to match the register, judges each result. The bench also checks that the paired results differ by exactly one.

// File: rtl/csa_pkg.sv
// Package: shared constants and types for the conditional sum adder.
// Assumes: nothing; included first in compile order.
package csa_pkg;

    // Default word and digit widths
    localparam int unsigned CSA_WIDTH_DEF = 32;
    localparam int unsigned CSA_DIGIT_DEF = 4;

    // How a bit's propagate term is formed
    typedef enum logic {
        PROP_XOR = 1'b0,
        PROP_OR  = 1'b1
    } prop_kind_e;

endpackage

// File: rtl/csa_digit.sv
// Module: csa_digit
// Makes both candidate sums and carries for one digit: one for carry-in 0
// (n) and one for carry-in 1 (e), each by lookahead over the digit's bits.
// Assumes: DW >= 1; purely combinational.
module csa_digit
    import csa_pkg::*;
#(
    parameter int unsigned DW = 4,
    parameter prop_kind_e  PK = PROP_XOR
) (
    input  logic [DW-1:0] a_i,
    input  logic [DW-1:0] b_i,
    output logic [DW-1:0] sn_o,
    output logic [DW-1:0] se_o,
    output logic          cn_o,
    output logic          ce_o
);

    logic [DW-1:0] gen_b;
    logic [DW-1:0] half_b;
    logic [DW-1:0] prop_b;
    logic [DW:0]   cin_n;
    logic [DW:0]   cin_e;
    logic          chain;
    logic [DW:0]   step_one;

    assign step_one = {{DW{1'b0}}, 1'b1};

    // Per-bit generate and half-sum terms
    assign gen_b  = a_i & b_i;
    assign half_b = a_i ^ b_i;

    // Propagate term variant picked by parameter
    generate
        if (PK == PROP_OR) begin : g_prop_or
            assign prop_b = a_i | b_i;
        end else begin : g_prop_xor
            assign prop_b = half_b;
        end
    endgenerate

    // Lookahead carry into every bit for both assumed carry-ins
    always_comb begin
        chain = 1'b1;
        for (int i = 0; i <= int'(DW); i++) begin
            cin_n[i] = 1'b0;
            chain    = 1'b1;
            for (int j = i - 1; j >= 0; j--) begin
                cin_n[i] = cin_n[i] | (gen_b[j] & chain);
                chain    = chain & prop_b[j];
            end
            cin_e[i] = cin_n[i] | chain;
        end
    end

    // Candidate sum bits and digit carry-outs
    assign sn_o = half_b ^ cin_n[DW-1:0];
    assign se_o = half_b ^ cin_e[DW-1:0];
    assign cn_o = cin_n[DW];
    assign ce_o = cin_e[DW];

    // Guard: candidates are one apart; bit 0 candidates are complements
    always_comb begin
        p_digit_step_r3 : assert ({ce_o, se_o} == ({cn_o, sn_o} + step_one))
            else $error("digit candidates not one apart");
        p_digit_bit0_r2 : assert (se_o[0] == ~sn_o[0])
            else $error("digit bit0 candidates not complementary");
    end

endmodule

// File: rtl/csa_merge.sv
// Module: csa_merge
// Joins a low and a high group of GW bits into one group of 2*GW bits. The
// low sums pass through, and the low carries pick the high candidates.
// Assumes: inputs satisfy cn_lo -> ce_lo (carry-in-1 carry never below
// carry-in-0 carry); purely combinational.
module csa_merge #(
    parameter int unsigned GW = 4
) (
    input  logic [GW-1:0]   sn_lo_i,
    input  logic [GW-1:0]   se_lo_i,
    input  logic            cn_lo_i,
    input  logic            ce_lo_i,
    input  logic [GW-1:0]   sn_hi_i,
    input  logic [GW-1:0]   se_hi_i,
    input  logic            cn_hi_i,
    input  logic            ce_hi_i,
    output logic [2*GW-1:0] sn_o,
    output logic [2*GW-1:0] se_o,
    output logic            cn_o,
    output logic            ce_o
);

    localparam int unsigned OW = 2 * GW;

    logic [GW-1:0] hi_n;
    logic [GW-1:0] hi_e;
    logic [OW:0]   step_one;

    assign step_one = {{OW{1'b0}}, 1'b1};

    // Pick high candidates from the pair of low carries
    always_comb begin
        unique case ({ce_lo_i, cn_lo_i})
            2'b00: begin
                hi_n = sn_hi_i;
                hi_e = sn_hi_i;
                cn_o = cn_hi_i;
                ce_o = cn_hi_i;
            end
            2'b11: begin
                hi_n = se_hi_i;
                hi_e = se_hi_i;
                cn_o = ce_hi_i;
                ce_o = ce_hi_i;
            end
            default: begin
                hi_n = sn_hi_i;
                hi_e = se_hi_i;
                cn_o = cn_hi_i;
                ce_o = ce_hi_i;
            end
        endcase
    end

    // Assemble merged candidates, low half untouched
    assign sn_o = {hi_n, sn_lo_i};
    assign se_o = {hi_e, se_lo_i};

    // Guard: low carries ordered, merged candidates one apart
    always_comb begin
        p_lo_carry_order_r3 : assert (!cn_lo_i || ce_lo_i)
            else $error("low group carry order broken");
        p_merge_step_r4 : assert ({ce_o, se_o} == ({cn_o, sn_o} + step_one))
            else $error("merged candidates not one apart");
    end

endmodule

// File: rtl/csa_tree.sv
// Module: csa_tree
// Builds the digit row and the doubling merge tree. Its outputs are the
// full-width carry-in-0 and carry-in-1 candidates.
// Assumes: WIDTH / DIGIT is a power of two and at least 2.
module csa_tree
    import csa_pkg::*;
#(
    parameter int unsigned WIDTH = CSA_WIDTH_DEF,
    parameter int unsigned DIGIT = CSA_DIGIT_DEF,
    parameter prop_kind_e  PK    = PROP_XOR
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output logic [WIDTH-1:0] sn_o,
    output logic [WIDTH-1:0] se_o,
    output logic             cn_o,
    output logic             ce_o
);

    localparam int unsigned NDIG   = WIDTH / DIGIT;
    localparam int unsigned LEVELS = $clog2(NDIG);

    logic [LEVELS:0][WIDTH-1:0] sn_l;
    logic [LEVELS:0][WIDTH-1:0] se_l;
    logic [LEVELS:0][NDIG-1:0]  cn_l;
    logic [LEVELS:0][NDIG-1:0]  ce_l;

    // Row of digit candidate generators
    generate
        for (genvar d = 0; d < NDIG; d++) begin : g_dig
            csa_digit #(.DW(DIGIT), .PK(PK)) u_dig (
                .a_i  (a_i[d*DIGIT +: DIGIT]),
                .b_i  (b_i[d*DIGIT +: DIGIT]),
                .sn_o (sn_l[0][d*DIGIT +: DIGIT]),
                .se_o (se_l[0][d*DIGIT +: DIGIT]),
                .cn_o (cn_l[0][d]),
                .ce_o (ce_l[0][d])
            );
        end
    endgenerate

    // Doubling merge levels
    generate
        for (genvar k = 0; k < LEVELS; k++) begin : g_lvl
            localparam int unsigned GW  = DIGIT << k;
            localparam int unsigned CNT = NDIG >> (k + 1);
            for (genvar j = 0; j < CNT; j++) begin : g_pair
                csa_merge #(.GW(GW)) u_mrg (
                    .sn_lo_i (sn_l[k][(2*j)*GW +: GW]),
                    .se_lo_i (se_l[k][(2*j)*GW +: GW]),
                    .cn_lo_i (cn_l[k][2*j]),
                    .ce_lo_i (ce_l[k][2*j]),
                    .sn_hi_i (sn_l[k][(2*j+1)*GW +: GW]),
                    .se_hi_i (se_l[k][(2*j+1)*GW +: GW]),
                    .cn_hi_i (cn_l[k][2*j+1]),
                    .ce_hi_i (ce_l[k][2*j+1]),
                    .sn_o    (sn_l[k+1][j*2*GW +: 2*GW]),
                    .se_o    (se_l[k+1][j*2*GW +: 2*GW]),
                    .cn_o    (cn_l[k+1][j]),
                    .ce_o    (ce_l[k+1][j])
                );
            end
            // Tie off carry slots left empty at this level
            if (CNT < NDIG) begin : g_tie
                assign cn_l[k+1][NDIG-1:CNT] = '0;
                assign ce_l[k+1][NDIG-1:CNT] = '0;
            end
        end
    endgenerate

    // Root of the tree
    assign sn_o = sn_l[LEVELS];
    assign se_o = se_l[LEVELS];
    assign cn_o = cn_l[LEVELS][0];
    assign ce_o = ce_l[LEVELS][0];

endmodule

// File: rtl/cond_sum_adder.sv
// Module: cond_sum_adder (top)
// Conditional-sum adder: the merge tree supplies both full-width
// candidates, cin selects one, and an optional register holds the result.
// Assumes: WIDTH / DIGIT is a power of two; synchronous active-low reset.
module cond_sum_adder
    import csa_pkg::*;
#(
    parameter int unsigned WIDTH   = CSA_WIDTH_DEF,
    parameter int unsigned DIGIT   = CSA_DIGIT_DEF,
    parameter prop_kind_e  PK      = PROP_XOR,
    parameter bit          REG_OUT = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             cout
);

    logic [WIDTH-1:0] cand_n;
    logic [WIDTH-1:0] cand_e;
    logic             carry_n;
    logic             carry_e;
    logic [WIDTH-1:0] sum_c;
    logic             cout_c;

    // Candidate generation and merge tree
    csa_tree #(.WIDTH(WIDTH), .DIGIT(DIGIT), .PK(PK)) u_tree (
        .a_i  (a),
        .b_i  (b),
        .sn_o (cand_n),
        .se_o (cand_e),
        .cn_o (carry_n),
        .ce_o (carry_e)
    );

    // Final pick by the real carry-in
    assign sum_c  = cin ? cand_e  : cand_n;
    assign cout_c = cin ? carry_e : carry_n;

    generate
        if (REG_OUT) begin : g_reg
            logic [WIDTH-1:0] sum_q;
            logic             cout_q;

            // Output register with synchronous clear
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    sum_q  <= '0;
                    cout_q <= 1'b0;
                end else begin
                    sum_q  <= sum_c;
                    cout_q <= cout_c;
                end
            end

            assign sum  = sum_q;
            assign cout = cout_q;

            // Result equals the previous cycle's arithmetic sum
            p_add_result_r1 : assert property (@(posedge clk) disable iff (!rst_n)
                $past(rst_n) |-> ({cout, sum} ==
                    ({1'b0, $past(a)} + {1'b0, $past(b)} + {{WIDTH{1'b0}}, $past(cin)})))
                else $error("registered result differs from a+b+cin");

            // Clear state seen right after reset is released
            p_reset_clear_r6 : assert property (@(posedge clk)
                $rose(rst_n) |-> (sum == '0 && !cout))
                else $error("outputs not cleared by reset");
        end else begin : g_comb
            assign sum  = sum_c;
            assign cout = cout_c;
        end
    endgenerate

endmodule

// File: tb/test_cond_sum_adder.sv
// Bench for cond_sum_adder: a queued behavioural reference, compared at
// every falling edge.
module test_cond_sum_adder;

    localparam int unsigned W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] a = '0;
    logic [W-1:0] b = '0;
    logic         cin = 1'b0;
    logic [W-1:0] sum;
    logic         cout;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [W:0] exp_q[$];
    string      tag_q[$];
    logic [W:0] last_exp;
    bit         have_last = 1'b0;

    always #10 clk = ~clk;

    cond_sum_adder i_cond_sum_adder (
        .clk   (clk),
        .rst_n (rst_n),
        .a     (a),
        .b     (b),
        .cin   (cin),
        .sum   (sum),
        .cout  (cout)
    );

    task automatic check(input string req, input logic [W:0] act, input logic [W:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // At a falling edge: judge the pending result, then drive the next vector
    task automatic apply(input logic [W-1:0] va, input logic [W-1:0] vb,
                         input logic vc, input string req);
        @(negedge clk);
        if (exp_q.size() > 0) begin
            last_exp = exp_q.pop_front();
            check(tag_q.pop_front(), {cout, sum}, last_exp);
            have_last = 1'b1;
        end else begin
            have_last = 1'b0;
        end
        rst_n = 1'b1;
        a = va;
        b = vb;
        cin = vc;
        exp_q.push_back({1'b0, va} + {1'b0, vb} + {{W{1'b0}}, vc});
        tag_q.push_back(req);
        // R8: new operands must not show before the next rising edge
        #2;
        if (have_last) check("R8 hold", {cout, sum}, last_exp);
    endtask

    task automatic pair(input logic [W-1:0] va, input logic [W-1:0] vb, input string req);
        apply(va, vb, 1'b0, req);
        apply(va, vb, 1'b1, req);
    endtask

    // Flush the last pending result
    task automatic drain();
        @(negedge clk);
        while (exp_q.size() > 0) check(tag_q.pop_front(), {cout, sum}, exp_q.pop_front());
    endtask

    // Reset with busy inputs; outputs must read zero
    task automatic reset_phase(input logic [W-1:0] va);
        drain();
        rst_n = 1'b0;
        a = va;
        b = ~va;
        cin = 1'b1;
        @(negedge clk);
        check("R6 reset", {cout, sum}, '0);
        @(negedge clk);
        check("R6 reset", {cout, sum}, '0);
    endtask

    initial begin : watchdog
        #(20 * 200000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin : stim
        logic [W-1:0] ps;
        logic [W:0]   r0;
        a = 32'h1234_5678;
        b = 32'h9ABC_DEF0;
        cin = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R6 reset", {cout, sum}, '0);

        // Zero and carry-in selection
        pair(32'h0000_0000, 32'h0000_0000, "R5 R1 zero");
        // Digit-boundary carries
        pair(32'h0000_000F, 32'h0000_0001, "R2 digit");
        pair(32'h0000_00F8, 32'h0000_0008, "R2 digit");
        // Carries crossing 2, 4 and 8 digit groups
        pair(32'h0000_00FF, 32'h0000_0001, "R4 group2");
        pair(32'h0000_FFFF, 32'h0000_0000, "R4 group4");
        pair(32'h00FF_FFFF, 32'h0000_0001, "R4 group6");
        pair(32'h0FFF_FFFF, 32'h0000_0001, "R4 group8");
        pair(32'hFFFF_0000, 32'h0000_FFFF, "R4 R3 highrun");
        // Full-width ripple
        apply(32'hFFFF_FFFF, 32'h0000_0000, 1'b1, "R7 allones");
        apply(32'hFFFF_FFFF, 32'h0000_0001, 1'b0, "R7 allones");
        pair(32'hFFFF_FFFF, 32'hFFFF_FFFF, "R7 R1 max");
        // Alternating patterns
        pair(32'hAAAA_AAAA, 32'h5555_5555, "R5 R3 alt");
        pair(32'h5555_5555, 32'h5555_5555, "R1 alt");
        pair(32'hAAAA_AAAA, 32'hAAAA_AAAA, "R1 alt");

        reset_phase(32'hDEAD_BEEF);

        // R5 R3: same operands give results exactly one apart
        for (int n = 0; n < 200; n++) begin
            ps = $urandom();
            apply(ps, ~ps, 1'b0, "R5 pair");
            @(negedge clk);
            r0 = {cout, sum};
            check(tag_q.pop_front(), r0, exp_q.pop_front());
            a = ps;
            b = ~ps;
            cin = 1'b1;
            exp_q.push_back({1'b0, ps} + {1'b0, ~ps} + 33'd1);
            tag_q.push_back("R5 pair");
            @(negedge clk);
            check("R3 R5 step", {cout, sum}, r0 + 33'd1);
            check(tag_q.pop_front(), {cout, sum}, exp_q.pop_front());
        end

        // R1 random operands
        for (int n = 0; n < 3000; n++) begin
            apply($urandom(), $urandom(), 1'($urandom()), "R1 random");
        end
        drain();

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule